// File: doc/BRIEF.md
# Single-Entry Line Writeback Buffer

This block sits in a bus interface unit and sequences the eviction of one modified data-cache line at a time. It holds the line in a single 32-byte holding register and writes it to memory as a burst of 64-bit beats. Three causes can request an eviction: a line replacement on a data-cache read miss, a whole-cache writeback-and-invalidate instruction, and the external flush pin. The cache array, the bus protocol and the sequencer that walks the cache during a flush are outside the block.

For a replacement, the bus read of the incoming line is launched first. The victim is copied into the holding register only in the cycle in which that read is granted. The victim is written out only after the fill reports completion. Evictions from the instruction or from a flush have no fill to wait for, so the line is captured at once and written straight away. While an entry is held, the block stalls further eviction requests and reports itself busy.

The held entry stays visible to address-compare snoops from instruction-fetch misses and from external inquire cycles. A matching snoop returns a hit together with the whole buffered line.

Top module: `line_wb_buffer`

## Requirements
- R1: After reset, valid_o, busy_o, fill_req_o, wr_req_o, evict_ack_o (with no request) and every snp_hit_o bit are 0.
- R2: When an idle buffer sees evict_req_i with cause code 0 (replacement), fill_req_o is 1 from the next cycle, with fill_addr_o equal to fill_addr_i. evict_ack_o stays 0 until fill_gnt_i, and it is 1 in the cycle in which fill_gnt_i is 1. That cycle is the one that captures evict_addr_i and evict_line_i.
- R3: After a replacement capture, wr_req_o stays 0 until fill_done_i is seen, and wr_req_o is 1 in the cycle after fill_done_i.
- R4: When an idle buffer sees evict_req_i with cause code 1 (instruction), 2 (flush) or 3 (treated as flush), evict_ack_o is 1 in that same cycle, the line is captured, and wr_req_o is 1 in the next cycle with no fill request.
- R5: The writeback is 4 beats, issued in ascending order. Beat k carries wr_data_o = line bits [64k+63:64k] and wr_addr_o = line base + 8k, where the line base is evict_addr_i with its low 5 bits cleared. wr_last_o is 1 only on beat 3. A beat holds its address and data steady until wr_ack_i.
- R6: valid_o is 1 from the cycle after capture through the cycle of the final beat acknowledge, and 0 after it. busy_o is 0 again at that point too.
- R7: busy_o is 1 whenever a sequence is in progress. An evict_req_i made while busy gets evict_ack_o = 0 and does not disturb the buffered line or the burst.
- R8: snp_hit_o[p] is 1 when snp_req_i[p] is 1, the entry is valid, and address bits [31:5] of port p equal those of the held line; the low 5 bits are ignored. snp_data_o then carries the whole held line.
- R9: snp_hit_o[p] is 0 when the entry is invalid, when the line bits differ, or when snp_req_i[p] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evict_req_i | input | 1 | Eviction request, held until acknowledged |
| evict_cause_i | input | 2 | 0 replacement, 1 instruction, 2 flush, 3 as flush |
| evict_addr_i | input | 32 | Address of the victim line |
| evict_line_i | input | 256 | Victim line data |
| fill_addr_i | input | 32 | Address of the incoming line for a replacement |
| evict_ack_o | output | 1 | Victim captured this cycle |
| busy_o | output | 1 | Sequence in progress; new requests stall |
| valid_o | output | 1 | Holding register contains an unwritten line |
| fill_req_o | output | 1 | Fill read request to the bus |
| fill_addr_o | output | 32 | Fill read address |
| fill_gnt_i | input | 1 | Fill read issued on the bus |
| fill_done_i | input | 1 | Fill read completed |
| wr_req_o | output | 1 | Write beat request |
| wr_addr_o | output | 32 | Write beat address |
| wr_data_o | output | 64 | Write beat data |
| wr_last_o | output | 1 | Final beat of the burst |
| wr_ack_i | input | 1 | Write beat accepted |
| snp_req_i | input | 2 | Snoop request per port (0 fetch miss, 1 inquire) |
| snp_addr_i | input | 64 | Snoop addresses, port p in bits [32p+31:32p] |
| snp_hit_o | output | 2 | Snoop hit per port |
| snp_data_o | output | 256 | Held line data |

## Verification
The bench drives every cause code with long and short gaps before the grant, the fill completion and each beat acknowledge. It goes after three orderings. A design that captured the victim before the grant would raise the acknowledge early. One that did not wait for fill completion would show a write beat while the fill is open. One that dropped valid on the wrong beat would lose the last beat or keep answering snoops afterwards. Snoops use every offset within the line and a neighbouring line, so a compare that included the offset bits, or ignored the valid bit, produces a wrong hit. Requests made while busy check that a design accepting them would overwrite the held line in the middle of a burst.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
  typedef enum logic [1:0] {
    CAUSE_REPL  = 2'd0,
    CAUSE_INSTR = 2'd1,
    CAUSE_FLUSH = 2'd2,
    CAUSE_RSVD  = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_FILL_ISSUE = 2'd1,
    ST_FILL_WAIT  = 2'd2,
    ST_WRITE      = 2'd3
  } state_e;
endpackage

// File: rtl/lwb_ctrl.sv
module lwb_ctrl
  import lwb_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evict_req_i,
  input  logic [1:0]       cause_i,
  input  logic             fill_gnt_i,
  input  logic             fill_done_i,
  input  logic             wr_ack_i,
  output logic             capture_o,
  output logic             release_o,
  output logic             fill_req_o,
  output logic             wr_req_o,
  output logic             wr_last_o,
  output logic [IDX_W-1:0] beat_o,
  output logic             busy_o
);
  localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(BEATS - 1);

  state_e           state_q, state_d;
  logic [IDX_W-1:0] beat_q, beat_d;
  logic             fill_pend_q;

  always_comb begin
    state_d   = state_q;
    beat_d    = beat_q;
    capture_o = 1'b0;
    release_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (evict_req_i) begin
          if (cause_e'(cause_i) == CAUSE_REPL) begin
            state_d = ST_FILL_ISSUE;
          end else begin
            capture_o = 1'b1;
            beat_d    = '0;
            state_d   = ST_WRITE;
          end
        end
      end
      ST_FILL_ISSUE: begin
        // victim copy only once the fill read is on the bus
        if (fill_gnt_i) begin
          capture_o = 1'b1;
          state_d   = ST_FILL_WAIT;
        end
      end
      ST_FILL_WAIT: begin
        if (fill_done_i) begin
          beat_d  = '0;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (wr_ack_i) begin
          if (beat_q == LAST_BEAT) begin
            release_o = 1'b1;
            state_d   = ST_IDLE;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      beat_q      <= '0;
      fill_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      if (state_q == ST_FILL_ISSUE && fill_gnt_i) fill_pend_q <= 1'b1;
      else if (fill_done_i)                      fill_pend_q <= 1'b0;
    end
  end

  assign fill_req_o = (state_q == ST_FILL_ISSUE);
  assign wr_req_o   = (state_q == ST_WRITE);
  assign wr_last_o  = wr_req_o && (beat_q == LAST_BEAT);
  assign beat_o     = beat_q;
  assign busy_o     = (state_q != ST_IDLE);

  AST_NO_WRITE_DURING_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> !fill_pend_q); // R3
  AST_BURST_CONTINUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_ack_i && !wr_last_o) |=> wr_req_o); // R5
  AST_FILL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_gnt_i) |=> fill_req_o); // R2
endmodule

// File: rtl/lwb_entry.sv
module lwb_entry #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 256,
  parameter int OFF_W  = 5,
  parameter int N_SNP  = 2,
  localparam int TAG_W = ADDR_W - OFF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    capture_i,
  input  logic                    release_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LINE_W-1:0]       line_i,
  input  logic [N_SNP-1:0]        snp_req_i,
  input  logic [N_SNP*ADDR_W-1:0] snp_addr_i,
  output logic                    valid_o,
  output logic [TAG_W-1:0]        tag_o,
  output logic [LINE_W-1:0]       line_o,
  output logic [N_SNP-1:0]        snp_hit_o
);
  logic              valid_q;
  logic [TAG_W-1:0]  tag_q;
  logic [LINE_W-1:0] line_q;
  logic              unused_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      line_q  <= '0;
    end else begin
      if (capture_i) begin
        valid_q <= 1'b1;
        tag_q   <= addr_i[ADDR_W-1:OFF_W];
        line_q  <= line_i;
      end else if (release_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  for (genvar p = 0; p < N_SNP; p++) begin : g_snp
    assign snp_hit_o[p] = snp_req_i[p] && valid_q &&
                          (snp_addr_i[p*ADDR_W+OFF_W +: TAG_W] == tag_q);
  end

  assign unused_off = ^{snp_addr_i, addr_i[OFF_W-1:0]};
  assign valid_o    = valid_q;
  assign tag_o      = tag_q;
  assign line_o     = line_q;

  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |-> !valid_q); // R7
  AST_HELD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !capture_i && !release_i) |=> ($stable(line_q) && $stable(tag_q))); // R7
  AST_RELEASE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> !valid_q); // R6
endmodule

// File: rtl/lwb_beat.sv
module lwb_beat #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 256,
  parameter int BEAT_W = 64,
  parameter int OFF_W  = 5,
  localparam int BEATS  = LINE_W / BEAT_W,
  localparam int IDX_W  = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int BOFF_W = $clog2(BEAT_W / 8),
  localparam int TAG_W  = ADDR_W - OFF_W
) (
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [IDX_W-1:0]  beat_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] data_o
);
  logic [OFF_W-1:0] off;

  assign off    = OFF_W'(beat_i) << BOFF_W;
  assign addr_o = {tag_i, off};
  assign data_o = line_i[beat_i*BEAT_W +: BEAT_W];
endmodule

// File: rtl/line_wb_buffer.sv
module line_wb_buffer
  import lwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 256,
  parameter int BEAT_W = 64,
  parameter int N_SNP  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    evict_req_i,
  input  logic [1:0]              evict_cause_i,
  input  logic [ADDR_W-1:0]       evict_addr_i,
  input  logic [LINE_W-1:0]       evict_line_i,
  input  logic [ADDR_W-1:0]       fill_addr_i,
  output logic                    evict_ack_o,
  output logic                    busy_o,
  output logic                    valid_o,
  output logic                    fill_req_o,
  output logic [ADDR_W-1:0]       fill_addr_o,
  input  logic                    fill_gnt_i,
  input  logic                    fill_done_i,
  output logic                    wr_req_o,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output logic [BEAT_W-1:0]       wr_data_o,
  output logic                    wr_last_o,
  input  logic                    wr_ack_i,
  input  logic [N_SNP-1:0]        snp_req_i,
  input  logic [N_SNP*ADDR_W-1:0] snp_addr_i,
  output logic [N_SNP-1:0]        snp_hit_o,
  output logic [LINE_W-1:0]       snp_data_o
);
  localparam int BEATS = LINE_W / BEAT_W;
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int OFF_W = $clog2(LINE_W / 8);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic              capture, release_e;
  logic [IDX_W-1:0]  beat;
  logic [TAG_W-1:0]  tag;
  logic [LINE_W-1:0] line;

  lwb_ctrl #(.BEATS(BEATS)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evict_req_i (evict_req_i),
    .cause_i     (evict_cause_i),
    .fill_gnt_i  (fill_gnt_i),
    .fill_done_i (fill_done_i),
    .wr_ack_i    (wr_ack_i),
    .capture_o   (capture),
    .release_o   (release_e),
    .fill_req_o  (fill_req_o),
    .wr_req_o    (wr_req_o),
    .wr_last_o   (wr_last_o),
    .beat_o      (beat),
    .busy_o      (busy_o)
  );

  lwb_entry #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .OFF_W(OFF_W), .N_SNP(N_SNP)
  ) i_entry (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture),
    .release_i  (release_e),
    .addr_i     (evict_addr_i),
    .line_i     (evict_line_i),
    .snp_req_i  (snp_req_i),
    .snp_addr_i (snp_addr_i),
    .valid_o    (valid_o),
    .tag_o      (tag),
    .line_o     (line),
    .snp_hit_o  (snp_hit_o)
  );

  lwb_beat #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .BEAT_W(BEAT_W), .OFF_W(OFF_W)
  ) i_beat (
    .tag_i  (tag),
    .line_i (line),
    .beat_i (beat),
    .addr_o (wr_addr_o),
    .data_o (wr_data_o)
  );

  assign evict_ack_o = capture;
  assign fill_addr_o = fill_addr_i;
  assign snp_data_o  = line;

  AST_ACK_AFTER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_ack_o && cause_e'(evict_cause_i) == CAUSE_REPL) |-> fill_gnt_i); // R2
  AST_BEAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R5
  AST_LAST_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_ack_i && wr_last_o) |=> (!valid_o && !busy_o)); // R6
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_hit_o != '0) |-> valid_o); // R9
  AST_WRITE_HAS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> valid_o); // R6
endmodule

// File: tb/test_line_wb_buffer.sv
`timescale 1ns/1ps
module test_line_wb_buffer;
  localparam int AW = 32;
  localparam int LW = 256;
  localparam int BW = 64;
  localparam int NS = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evict_req = 1'b0;
  logic [1:0]    evict_cause = '0;
  logic [AW-1:0] evict_addr = '0;
  logic [LW-1:0] evict_line = '0;
  logic [AW-1:0] fill_addr = '0;
  logic          evict_ack, busy, valid, fill_req;
  logic [AW-1:0] fill_addr_q;
  logic          fill_gnt = 1'b0, fill_done = 1'b0;
  logic          wr_req, wr_last;
  logic [AW-1:0] wr_addr;
  logic [BW-1:0] wr_data;
  logic          wr_ack = 1'b0;
  logic [NS-1:0] snp_req = '0;
  logic [NS*AW-1:0] snp_addr = '0;
  logic [NS-1:0] snp_hit;
  logic [LW-1:0] snp_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  line_wb_buffer i_line_wb_buffer (
    .clk_i(clk), .rst_ni(rst_n),
    .evict_req_i(evict_req), .evict_cause_i(evict_cause),
    .evict_addr_i(evict_addr), .evict_line_i(evict_line),
    .fill_addr_i(fill_addr), .evict_ack_o(evict_ack), .busy_o(busy),
    .valid_o(valid), .fill_req_o(fill_req), .fill_addr_o(fill_addr_q),
    .fill_gnt_i(fill_gnt), .fill_done_i(fill_done),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_last_o(wr_last), .wr_ack_i(wr_ack),
    .snp_req_i(snp_req), .snp_addr_i(snp_addr),
    .snp_hit_o(snp_hit), .snp_data_o(snp_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] beat_val(input int s, input int k);
    return (64'h0123_4567_89AB_CDEF * 64'(s + 1)) ^ (64'(k) * 64'h1111_0000_1111_0001);
  endfunction

  function automatic logic [LW-1:0] line_val(input int s);
    logic [LW-1:0] l;
    for (int k = 0; k < 4; k++) l[k*64 +: 64] = beat_val(s, k);
    return l;
  endfunction

  // snoop every port against the held line: hit on own line (any offset), miss on neighbour
  task automatic snoop_probe(input logic [AW-1:0] base, input logic [LW-1:0] exp_line, input bit exp_valid);
    for (int p = 0; p < NS; p++) begin
      for (int off = 0; off < 32; off += 7) begin
        snp_req = '0;
        snp_req[p] = 1'b1;
        snp_addr[p*AW +: AW] = base + AW'(off);
        #1;
        chk(snp_hit[p] == exp_valid, "R8 snoop own line", 64'(snp_hit), 64'(exp_valid));
        if (exp_valid) chk(snp_data == exp_line, "R8 snoop data", snp_data[63:0], exp_line[63:0]);
      end
      snp_addr[p*AW +: AW] = base + 32'h20;
      #1;
      chk(snp_hit[p] == 1'b0, "R9 snoop neighbour line", 64'(snp_hit), 64'd0);
      snp_addr[p*AW +: AW] = base;
      snp_req = '0;
      #1;
      chk(snp_hit == '0, "R9 snoop no request", 64'(snp_hit), 64'd0);
    end
  endtask

  task automatic run_evict(input int cause, input int s);
    logic [AW-1:0] base;
    logic [LW-1:0] l;
    base = 32'h1000_0000 + AW'(s) * 32'h140 + AW'(cause) * 32'h2000;
    l    = line_val(s);
    @(negedge clk);
    evict_req   = 1'b1;
    evict_cause = 2'(cause);
    evict_addr  = base | 32'h13;
    evict_line  = l;
    fill_addr   = 32'h2000_0000 + AW'(s) * 32'h20;
    #1;
    if (cause == 0) begin
      chk(evict_ack == 1'b0, "R2 no ack before fill", 64'(evict_ack), 64'd0);
      @(negedge clk);
      chk(fill_req == 1'b1, "R2 fill request", 64'(fill_req), 64'd1);
      chk(fill_addr_q == fill_addr, "R2 fill address", 64'(fill_addr_q), 64'(fill_addr));
      chk(busy == 1'b1, "R7 busy in fill issue", 64'(busy), 64'd1);
      for (int d = 0; d < s; d++) begin
        chk(evict_ack == 1'b0 && valid == 1'b0, "R2 no capture before grant", 64'(evict_ack), 64'd0);
        @(negedge clk);
        chk(fill_req == 1'b1, "R2 fill held", 64'(fill_req), 64'd1);
      end
      fill_gnt = 1'b1;
      #1;
      chk(evict_ack == 1'b1, "R2 ack with grant", 64'(evict_ack), 64'd1);
      @(negedge clk);
      fill_gnt  = 1'b0;
      evict_req = 1'b0;
      evict_line = ~l;
      #1;
      chk(valid == 1'b1, "R6 valid after capture", 64'(valid), 64'd1);
      chk(fill_req == 1'b0, "R2 fill request dropped", 64'(fill_req), 64'd0);
      snoop_probe(base, l, 1'b1);
      // stalled request during fill wait
      evict_req = 1'b1;
      evict_cause = 2'd1;
      #1;
      chk(evict_ack == 1'b0, "R7 request stalled while busy", 64'(evict_ack), 64'd0);
      for (int d = 0; d < s + 1; d++) begin
        chk(wr_req == 1'b0, "R3 no write before fill done", 64'(wr_req), 64'd0);
        @(negedge clk);
        #1;
      end
      evict_req = 1'b0;
      evict_cause = 2'd0;
      fill_done = 1'b1;
      #1;
      chk(wr_req == 1'b0, "R3 no write in fill done cycle", 64'(wr_req), 64'd0);
      @(negedge clk);
      fill_done = 1'b0;
      #1;
      chk(wr_req == 1'b1, "R3 write after fill done", 64'(wr_req), 64'd1);
    end else begin
      chk(evict_ack == 1'b1, "R4 immediate ack", 64'(evict_ack), 64'd1);
      @(negedge clk);
      evict_req  = 1'b0;
      evict_line = ~l;
      #1;
      chk(wr_req == 1'b1 && fill_req == 1'b0, "R4 write follows capture", {62'd0, wr_req, fill_req}, 64'd2);
      chk(valid == 1'b1 && busy == 1'b1, "R6 valid busy after capture", {62'd0, valid, busy}, 64'd3);
      snoop_probe(base, l, 1'b1);
      evict_req = 1'b1;
      evict_cause = 2'd0;
      #1;
      chk(evict_ack == 1'b0, "R7 request stalled while writing", 64'(evict_ack), 64'd0);
      evict_req = 1'b0;
    end
    for (int k = 0; k < 4; k++) begin
      for (int d = 0; d < (k + s) % 3; d++) begin
        #1;
        chk(wr_req == 1'b1, "R5 beat pending", 64'(wr_req), 64'd1);
        chk(wr_addr == base + AW'(8 * k), "R5 beat address held", 64'(wr_addr), 64'(base + AW'(8 * k)));
        chk(wr_data == beat_val(s, k), "R5 beat data held", wr_data, beat_val(s, k));
        @(negedge clk);
      end
      wr_ack = 1'b1;
      #1;
      chk(wr_addr == base + AW'(8 * k), "R5 beat address", 64'(wr_addr), 64'(base + AW'(8 * k)));
      chk(wr_data == beat_val(s, k), "R5 beat data", wr_data, beat_val(s, k));
      chk(wr_last == (k == 3), "R5 last flag", 64'(wr_last), 64'(k == 3));
      chk(valid == 1'b1, "R6 valid through burst", 64'(valid), 64'd1);
      @(negedge clk);
      wr_ack = 1'b0;
    end
    #1;
    chk(valid == 1'b0 && busy == 1'b0 && wr_req == 1'b0, "R6 released after last beat",
        {61'd0, valid, busy, wr_req}, 64'd0);
    snoop_probe(base, l, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(valid == 1'b0 && busy == 1'b0, "R1 reset status", {62'd0, valid, busy}, 64'd0);
    chk(fill_req == 1'b0 && wr_req == 1'b0, "R1 reset requests", {62'd0, fill_req, wr_req}, 64'd0);
    chk(evict_ack == 1'b0, "R1 reset ack", 64'(evict_ack), 64'd0);
    snp_req = '1;
    #1;
    chk(snp_hit == '0, "R1 R9 no hit after reset", 64'(snp_hit), 64'd0);
    snp_req = '0;
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 4; c++) run_evict(c, s);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule